// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the 16x oversampling tick for a UART. A 16-bit divisor is held as two byte lanes behind a small register write and read port. A down-counter runs on the system clock and raises a one-cycle pulse on `baud_tick` once every divisor clocks. The serial bit rate is therefore the clock frequency divided by sixteen times the divisor. The shifters of a UART consume this pulse as their sampling strobe.

The divisor lanes share their addresses with two general holding registers. A line control register at its own address carries a divisor-access bit in bit position 7. While that bit is 1, addresses 0 and 1 reach the divisor's low and high byte. While it is 0, those addresses reach the holding registers instead, and the divisor cannot be changed. Any accepted divisor write reloads the counter from the new 16-bit value at once, so a new rate starts on a clean period boundary.

No data stream passes through this block. The register port is a plain single-cycle write strobe with a combinational read, so it has no valid/ready handshake and no back-pressure. The tick is a plain control pin.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the divisor is 0002h, the line control register reads 00h, and `baud_tick` is low while reset is asserted. The first tick comes on the second clock edge after reset is released.
- R2: For a divisor D of 2 or more, `baud_tick` is high after every D-th clock edge and low after every other edge. The count is taken from the last reload.
- R3: The reload value is the 16-bit value {byte at address 1, byte at address 0}, with address 0 as the low byte.
- R4: A divisor of 0001h keeps `baud_tick` high on every clock after the first edge that follows the reload.
- R5: A divisor of 0000h behaves exactly like 0001h.
- R6: A write to either divisor byte loads the full new divisor into the counter and restarts the count. `baud_tick` is low after the write edge, and the next tick follows D edges later.
- R7: While line control bit 7 is 0, writes to addresses 0 and 1 leave the divisor and the tick phase untouched. They store into the holding registers, and reads of addresses 0 and 1 return those holding registers.
- R8: Line control is written and read at address 3 at any time. While its bit 7 is 1, reads of addresses 0 and 1 return the divisor's low and high byte.
- R9: For a divisor of 2 or more, every tick pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for one clock |
| reg_addr | input | 3 | Register address: 0 and 1 are divisor bytes or holding registers, 3 is line control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| baud_tick | output | 1 | One-clock pulse per divisor period (16x rate) |

## Verification
The bench sweeps the divisor across every value from 1 to 24. It also tries high-byte-only and mixed values above 255, and the zero divisor. For each one it compares the tick against a count taken from the reload edge on every clock. A counter that wraps or reloads one step early or late would show a tick period off by one. Treating zero as a real count would stall the tick for 65536 clocks. A restart taken only from the low-byte write, or a restart that lets a pending end-of-count through, would show up as a misplaced first tick after a mid-period rewrite. Ungated writes would break the tick phase after a write with the access bit clear, and a wrong read mux would return the divisor instead of the holding registers.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int BYTE_W     = 8;
  localparam int ACCESS_BIT = 7;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/brg_regs.sv
module brg_regs
  import brg_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 3,
  parameter int LCR_ADDR  = 3,
  parameter int RESET_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  output byte_t             rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  div_next_o,
  output logic              div_load_o
);
  localparam int NB = DIV_W / BYTE_W;

  logic [NB-1:0][BYTE_W-1:0] div_q, div_d, hold_q, hold_d;
  logic [NB-1:0]             wr_div, wr_hold;
  byte_t                     lcr_q;
  logic                      access;
  logic                      wr_lcr;

  assign access = lcr_q[ACCESS_BIT];
  assign wr_lcr = we_i && (addr_i == ADDR_W'(LCR_ADDR));

  // one lane per divisor byte: the access bit steers a write to divisor or holding reg
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic hit;
    assign hit        = we_i && (addr_i == ADDR_W'(g));
    assign wr_div[g]  = hit && access;
    assign wr_hold[g] = hit && !access;
    assign div_d[g]   = wr_div[g]  ? wdata_i : div_q[g];
    assign hold_d[g]  = wr_hold[g] ? wdata_i : hold_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(RESET_DIV);
      hold_q <= '0;
      lcr_q  <= '0;
    end else begin
      div_q  <= div_d;
      hold_q <= hold_d;
      if (wr_lcr) lcr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = access ? div_q[i] : hold_q[i];
    end
    if (addr_i == ADDR_W'(LCR_ADDR)) rdata_o = lcr_q;
  end

  assign div_o      = div_q;
  assign div_next_o = div_d;
  assign div_load_o = |wr_div;

  // R7: with the access bit clear the divisor holds its value
  p_div_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable(div_q));
  // R7: holding registers do not move while divisor access is open
  p_hold_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> $stable(hold_q));
endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] cur_div_i,
  output logic             tick_o
);
  // zero divisor is folded onto one so the count never passes through zero
  function automatic logic [DIV_W-1:0] eff(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  localparam logic [DIV_W-1:0] RST_CNT = eff(DIV_W'(RESET_DIV));

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= RST_CNT;
      tick_o <= 1'b0;
    end else if (load_i) begin
      cnt    <= eff(load_val_i);
      tick_o <= 1'b0;
    end else if (cnt <= DIV_W'(1)) begin
      cnt    <= eff(cur_div_i);
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt - DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt > DIV_W'(1)) |=> (cnt == $past(cnt) - DIV_W'(1)) && !tick_o);
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt <= DIV_W'(1)) |=> tick_o && (cnt == eff($past(cur_div_i))));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !tick_o && (cnt == eff($past(load_val_i))));
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cnt > DIV_W'(1)) |=> !tick_o);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 3,
  parameter int LCR_ADDR  = 3,
  parameter int RESET_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              baud_tick
);
  logic [DIV_W-1:0] div_cur, div_next;
  logic             div_load;

  brg_regs #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .LCR_ADDR(LCR_ADDR), .RESET_DIV(RESET_DIV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .div_o(div_cur), .div_next_o(div_next), .div_load_o(div_load)
  );

  brg_counter #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .load_val_i(div_next),
    .cur_div_i(div_cur), .tick_o(baud_tick)
  );

  // R1: tick stays low in the clock after reset is seen
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !baud_tick);
endmodule

// File: tb/sim_uart_baud_gen.sv
module sim_uart_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  bit mon_on = 0;
  int mon_d = 1;
  int mon_e0 = 0;
  int mon_bad = 0;
  int bad_n = 0;
  logic bad_act = 1'b0;
  logic bad_exp = 1'b0;

  uart_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .baud_tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // tick expected after every mon_d-th edge since the reload edge
  always @(negedge clk) begin
    if (mon_on) begin
      int n;
      logic e;
      n = edge_cnt - mon_e0;
      e = (n > 0) && (n % mon_d == 0);
      if (tick !== e) begin
        if (mon_bad == 0) begin bad_n = n; bad_act = tick; bad_exp = e; end
        mon_bad++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic start_mon(input int d);
    mon_d = (d == 0) ? 1 : d;
    mon_e0 = edge_cnt;
    mon_bad = 0;
    mon_on = 1;
  endtask

  task automatic end_mon(input string req, input int d);
    mon_on = 0;
    checks++;
    if (mon_bad != 0) begin
      errors++;
      $display("FAIL %s divisor=%0d: tick actual=%b expected=%b at edge %0d",
               req, d, bad_act, bad_exp, bad_n);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    wr(3'd0, 8'(d));
    wr(3'd1, 8'(d >> 8));
    start_mon(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // R1: reset state
    wait_cyc(3);
    check(tick === 1'b0, "R1 tick in reset", int'(tick), 0);
    addr = 3'd3; #1;
    check(rdata === 8'h00, "R1 lcr reset", int'(rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    start_mon(2);
    wait_cyc(9);
    end_mon("R1 reset divisor period", 2);
    wr(3'd3, 8'h80);
    rd(3'd0, v); check(v === 8'h02, "R1 divisor low reset", int'(v), 2);
    rd(3'd1, v); check(v === 8'h00, "R1 divisor high reset", int'(v), 0);
    rd(3'd3, v); check(v === 8'h80, "R8 lcr readback", int'(v), 8'h80);

    // R2 / R4 / R9: sweep small divisors
    for (int d = 1; d <= 24; d++) begin
      set_div(d);
      wait_cyc(3 * d + 3);
      end_mon(d == 1 ? "R4 divide by one" : "R2 R9 period sweep", d);
    end

    // R5: zero divisor acts as one
    set_div(0);
    wait_cyc(8);
    end_mon("R5 zero divisor", 0);

    // R3: high byte takes part in the reload
    set_div(16'h0100);
    wait_cyc(2 * 256 + 3);
    end_mon("R3 high byte only", 16'h0100);
    set_div(16'h0203);
    wait_cyc(2 * 515 + 3);
    end_mon("R3 mixed bytes", 16'h0203);
    rd(3'd0, v); check(v === 8'h03, "R8 divisor low read", int'(v), 3);
    rd(3'd1, v); check(v === 8'h02, "R8 divisor high read", int'(v), 2);

    // R6: restart mid-period through low byte, then high byte
    set_div(10);
    wait_cyc(4);
    end_mon("R6 before restart", 10);
    wr(3'd0, 8'd10);
    start_mon(10);
    wait_cyc(13);
    end_mon("R6 low byte restart", 10);
    wr(3'd1, 8'd0);
    start_mon(10);
    wait_cyc(25);
    end_mon("R6 high byte restart", 10);

    // R7: gated writes leave divisor and phase alone
    set_div(3);
    wait_cyc(5);
    wr(3'd3, 8'h00);
    wait_cyc(2);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h66);
    wait_cyc(10);
    end_mon("R7 phase kept across gated writes", 3);
    rd(3'd0, v); check(v === 8'h55, "R7 holding low read", int'(v), 8'h55);
    rd(3'd1, v); check(v === 8'h66, "R7 holding high read", int'(v), 8'h66);
    rd(3'd3, v); check(v === 8'h00, "R8 lcr cleared", int'(v), 0);
    wr(3'd3, 8'h80);
    rd(3'd0, v); check(v === 8'h03, "R7 divisor low untouched", int'(v), 3);
    rd(3'd1, v); check(v === 8'h00, "R7 divisor high untouched", int'(v), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule